// File: doc/BRIEF.md
# Receive Ring Buffer Consumer

This block drains completed frames from a circular receive region kept in a local memory of 16-bit words. A separate receive engine deposits frames into the region. Each frame starts with a four-word header, followed by payload words. When the `start` input pulses, the block walks the ring from its head pointer. It reads each header and checks whether that frame is finished. A good frame's payload goes out on a valid/ready byte stream. A bad frame is dropped. After each frame, the head moves to the frame's stored next pointer.

The walk ends at the first frame whose completion word is not yet written. The block then moves the stop limit, which tells the receive engine how far it may write. The stop limit sits one word behind the head. When the head is at the very bottom of the region, the stop limit goes to the top of the region instead. Two counters tally the delivered frames and the dropped frames.

Memory addresses are byte addresses, always even. The receive region takes the lower three quarters of a memory of `2**AW` bytes. It runs from address 0 up to an upper limit equal to the region size minus 2. With the defaults (AW=13) the upper limit is 6142 (0x17FE).

Top module: `rx_ring_reader`

## Requirements
- R1: After reset the head is 0, `stop_limit` is the upper limit with its low byte forced to 0xFE, both counters are 0, `out_valid` is low and `busy` is low.
- R2: A pulse on `start` while idle begins a walk at the head. A frame is processed only when its first header word equals the completion code 0x0008. The walk ends at the first frame whose first word differs.
- R3: The header occupies four consecutive words in this order: completion code, status, next-frame pointer, byte count. After each processed frame, good or bad, the head takes the value of the next-frame pointer.
- R4: A frame whose status word has bit 13 set is good. Its payload is delivered and `good_cnt` rises by one. Any other frame produces no output beat and raises `bad_cnt` by one.
- R5: Payload words follow the header at increasing addresses. `out_data[7:0]` carries the earlier byte. `out_keep` is 2'b11 for a full word and 2'b01 for a lone final byte of an odd count. `out_last` marks the final beat. A good frame with a byte count of 0 emits no beat but is still counted as good.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_keep` and `out_last` hold their values.
- R7: Every read address steps by 2, and the step after the upper limit returns to address 0. This applies to header words and payload words alike.
- R8: When a walk ends, `stop_limit` becomes head minus 2. If the head is below 2, `stop_limit` becomes the upper limit instead. `stop_limit` changes at no other time.
- R9: A `start` pulse that arrives while `busy` is high is ignored and does not cause a later walk.
- R10: Memory reads use even addresses no greater than the upper limit. Read data returns one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a walk of the ring |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Byte address of the word being read |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| out_valid | output | 1 | Payload beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 16 | Payload word, earlier byte in bits 7:0 |
| out_keep | output | 2 | Byte enables of the beat |
| out_last | output | 1 | Final beat of the frame |
| head | output | AW | Address of the next header to examine |
| stop_limit | output | AW | Write limit handed back to the receive engine |
| good_cnt | output | CW | Delivered frame count |
| bad_cnt | output | CW | Dropped frame count |
| busy | output | 1 | A walk is in progress |

## Verification
Two things can happen in the same cycle:
- The acceptance of a frame's last payload beat coincides with the head moving to the next pointer and with the good counter incrementing. The bench provokes this with back-to-back frames, under both a steady and a randomly toggling `out_ready`. It then judges the result by the beat stream and the final head and counters.
- A second `start` pulse can land in the middle of a walk. The bench provokes this and then watches `busy` for several cycles after the walk ends, to confirm no extra walk starts.

The wrap of addresses past the upper limit is also exercised. So is the stop limit's wrap when the head lands on address 0.

// File: rtl/rx_ring_reader.sv
module rx_ring_reader #(
  parameter int AW = 13,
  parameter int CW = 16,
  parameter logic [15:0] DONE_CODE = 16'h0008,
  parameter int OK_BIT = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  output logic [1:0]    out_keep,
  output logic          out_last,
  output logic [AW-1:0] head,
  output logic [AW-1:0] stop_limit,
  output logic [CW-1:0] good_cnt,
  output logic [CW-1:0] bad_cnt,
  output logic          busy
);
  localparam int MEM_BYTES = 1 << AW;
  localparam int RX_BYTES  = MEM_BYTES * 3 / 4;
  localparam logic [AW-1:0] UPPER = AW'(RX_BYTES - 2);
  localparam logic [AW-1:0] LOWER = '0;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CAP, S_OUT, S_FIN} state_t;

  state_t        st;
  logic [AW-1:0] ptr, nxt;
  logic [1:0]    idx;
  logic          in_pay, ok_q;
  logic [15:0]   rem, word;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a >= UPPER) ? LOWER : a + AW'(2);
  endfunction

  assign mem_rd    = (st == S_REQ);
  assign mem_addr  = ptr;
  assign out_valid = (st == S_OUT);
  assign out_data  = word;
  assign out_keep  = (rem == 16'd1) ? 2'b01 : 2'b11;
  assign out_last  = (rem <= 16'd2);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr        <= LOWER;
      nxt        <= LOWER;
      idx        <= '0;
      in_pay     <= 1'b0;
      ok_q       <= 1'b0;
      rem        <= '0;
      word       <= '0;
      head       <= LOWER;
      stop_limit <= {UPPER[AW-1:8], 8'hFE};
      good_cnt   <= '0;
      bad_cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ptr    <= head;
          idx    <= '0;
          in_pay <= 1'b0;
          st     <= S_REQ;
        end
        S_REQ: st <= S_CAP;
        S_CAP: begin
          ptr <= step(ptr);
          if (in_pay) begin
            word <= mem_rdata;
            st   <= S_OUT;
          end else begin
            case (idx)
              2'd0: begin
                if (mem_rdata == DONE_CODE) begin
                  idx <= 2'd1;
                  st  <= S_REQ;
                end else st <= S_FIN;
              end
              2'd1: begin
                ok_q <= mem_rdata[OK_BIT];
                idx  <= 2'd2;
                st   <= S_REQ;
              end
              2'd2: begin
                nxt <= mem_rdata[AW-1:0];
                idx <= 2'd3;
                st  <= S_REQ;
              end
              default: begin
                rem <= mem_rdata;
                idx <= 2'd0;
                st  <= S_REQ;
                if (ok_q && mem_rdata != 16'd0) begin
                  in_pay <= 1'b1;
                end else begin
                  if (ok_q) good_cnt <= good_cnt + CW'(1);
                  else      bad_cnt  <= bad_cnt + CW'(1);
                  head <= nxt;
                  ptr  <= nxt;
                end
              end
            endcase
          end
        end
        S_OUT: if (out_ready) begin
          st <= S_REQ;
          if (out_last) begin
            good_cnt <= good_cnt + CW'(1);
            head     <= nxt;
            ptr      <= nxt;
            in_pay   <= 1'b0;
            rem      <= '0;
          end else begin
            rem <= rem - 16'd2;
          end
        end
        S_FIN: begin
          stop_limit <= (head < LOWER + AW'(2)) ? UPPER : head - AW'(2);
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last));

  a_r10_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_addr[0] && mem_addr <= UPPER);

  a_r8_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_limit) |-> $fell(busy));

  a_r4_good_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(good_cnt) |-> good_cnt == $past(good_cnt) + CW'(1));

  a_r4_bad_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bad_cnt) |-> bad_cnt == $past(bad_cnt) + CW'(1));

  a_r5_keep_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_keep != 2'b11 |-> out_keep == 2'b01 && out_last);
endmodule

// File: tb/rx_ring_reader_bench.sv
module rx_ring_reader_bench;
  localparam int AW = 13;
  localparam int CW = 16;
  localparam int UPPER = (1 << AW) * 3 / 4 - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic out_valid, out_ready, out_last, busy;
  logic [15:0] out_data;
  logic [1:0] out_keep;
  logic [AW-1:0] head, stop_limit;
  logic [CW-1:0] good_cnt, bad_cnt;

  always #5 clk = ~clk;

  rx_ring_reader #(.AW(AW), .CW(CW)) u_rx_ring_reader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last), .head(head),
    .stop_limit(stop_limit), .good_cnt(good_cnt), .bad_cnt(bad_cnt), .busy(busy));

  logic [15:0] mem [0:(1<<AW)/2-1];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[AW-1:1]];

  int tests = 0, fails = 0, cyc = 0;
  int exp_good = 0, exp_bad = 0, exp_head = 0;
  logic [18:0] beats [$];
  bit rdy_rand = 1'b0;
  bit stalled = 1'b0;
  logic [18:0] held;

  function automatic int step(int a);
    return (a >= UPPER) ? 0 : a + 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial out_ready = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (rst_n) begin
      if (stalled) begin
        check(out_valid && {out_last, out_keep, out_data} == held, "R6 stall hold",
              int'({out_last, out_keep, out_data}), int'(held));
      end
      if (mem_rd) check(!mem_addr[0] && int'(mem_addr) <= UPPER, "R10 read address", int'(mem_addr), UPPER);
      out_ready = rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;
      stalled = out_valid && !out_ready;
      held = {out_last, out_keep, out_data};
      if (out_valid && out_ready) begin
        if (beats.size() == 0) begin
          check(0, "R5 unexpected beat", int'(out_data), 0);
        end else begin
          logic [18:0] e;
          logic [15:0] msk;
          e = beats.pop_front();
          msk = (e[17:16] == 2'b01) ? 16'h00FF : 16'hFFFF;
          check(out_keep == e[17:16], "R5 keep", int'(out_keep), int'(e[17:16]));
          check(out_last == e[18], "R5 last", int'(out_last), int'(e[18]));
          check((out_data & msk) == (e[15:0] & msk), "R5 data", int'(out_data & msk), int'(e[15:0] & msk));
        end
      end
    end
  end

  task automatic put_frame(input int at, input bit ok, input int len, input int seed,
                           input int jump, output int nx);
    int a;
    a = at;
    mem[a/2] = 16'h0008; a = step(a);
    mem[a/2] = ok ? 16'h2081 : 16'hD081; a = step(a);
    begin
      int pa;
      pa = a; a = step(a);
      mem[a/2] = 16'(len); a = step(a);
      for (int w = 0; w < (len + 1) / 2; w++) begin
        logic [7:0] b0, b1;
        int r;
        b0 = 8'(seed + 2*w); b1 = 8'(seed + 2*w + 1); r = len - 2*w;
        mem[a/2] = (r >= 2) ? {b1, b0} : {8'hA5, b0};
        if (ok) beats.push_back({r <= 2, (r >= 2) ? 2'b11 : 2'b01, (r >= 2) ? {b1, b0} : {8'hA5, b0}});
        a = step(a);
      end
      nx = (jump >= 0) ? jump : a;
      mem[pa/2] = 16'(nx);
      if (jump < 0) mem[nx/2] = 16'h0000;
    end
    if (ok) exp_good++; else exp_bad++;
    exp_head = nx;
  endtask

  task automatic walk(input bit extra_start, input string tag);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
      if (extra_start && n == 6) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(!busy, {tag, " R2 walk ends"}, int'(busy), 0);
    check(int'(head) == exp_head, {tag, " R3 head"}, int'(head), exp_head);
    check(int'(good_cnt) == exp_good, {tag, " R4 good count"}, int'(good_cnt), exp_good);
    check(int'(bad_cnt) == exp_bad, {tag, " R4 bad count"}, int'(bad_cnt), exp_bad);
    check(beats.size() == 0, {tag, " R5 beats consumed"}, beats.size(), 0);
    begin
      int es;
      es = (exp_head < 2) ? UPPER : exp_head - 2;
      check(int'(stop_limit) == es, {tag, " R8 stop limit"}, int'(stop_limit), es);
    end
  endtask

  initial begin
    int n1;
    for (int i = 0; i < (1<<AW)/2; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(head == '0, "R1 head", int'(head), 0);
    check(int'(stop_limit) == (UPPER | 8'hFE), "R1 stop", int'(stop_limit), UPPER | 8'hFE);
    check(good_cnt == '0 && bad_cnt == '0, "R1 counters", int'(good_cnt) + int'(bad_cnt), 0);
    check(!out_valid && !busy, "R1 idle", int'(out_valid) + int'(busy), 0);

    put_frame(0, 1, 5, 8'h10, -1, n1);
    put_frame(n1, 0, 4, 8'h30, -1, n1);
    put_frame(n1, 1, 6, 8'h50, -1, n1);
    walk(1, "chain");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!busy, "R9 start during walk ignored", int'(busy), 0);
    end

    rdy_rand = 1'b1;
    put_frame(exp_head, 1, 1, 8'h70, -1, n1);
    put_frame(n1, 1, 0, 8'h00, -1, n1);
    put_frame(n1, 0, 3, 8'h80, -1, n1);
    put_frame(n1, 1, 7, 8'h90, -1, n1);
    walk(0, "stall");

    put_frame(exp_head, 0, 2, 8'h00, UPPER - 6, n1);
    put_frame(UPPER - 6, 1, 9, 8'hC0, -1, n1);
    walk(0, "R7 wrap");

    walk(0, "empty R2");

    put_frame(exp_head, 0, 1, 8'h00, 0, n1);
    mem[0] = 16'h0000;
    walk(0, "stop wrap R8");

    put_frame(0, 1, 3, 8'hE0, -1, n1);
    walk(0, "from zero");

    finish_run();
  end
endmodule